// File: doc/BRIEF.md
# Singleton Centroid Defuzzifier

This block turns the three aggregated rule strengths of a two-input fuzzy controller into one crisp signed control value. The value is scaled so that the signed 8-bit range stands for a drive voltage from -5 V to +5 V. Each output set is a singleton: one point on the output axis, held in a register that can be rewritten while the block runs. The block first adds the three strengths. It then divides each singleton position by that total with a combinational non-restoring divider that keeps eight fraction bits. Each quotient is multiplied by its own strength, and the three signed products are added, scaled back and clamped to the output range. All three divide and multiply paths run side by side in a single combinational stage.

A strength triple enters on a valid/ready channel. The result leaves one cycle later from an output register on a second valid/ready channel. Back-pressure works as follows. `in_ready` is high when the output register is empty or is being drained in the same cycle. A result that has been offered stays valid and unchanged until `out_ready` takes it. There is no deeper buffering, so a stalled output stalls the input in the next cycle. The singleton registers are loaded through plain configuration pins that need no handshake.

Top module: `defz_centroid`

## Requirements
- R1: After reset, `out_valid` is low and singletons 0, 1 and 2 hold -96, 0 and +96.
- R2: `in_ready` equals `!out_valid || out_ready`. A triple is accepted in a cycle where `in_valid` and `in_ready` are both high.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_crisp` does not change.
- R4: An accepted triple produces its result on `out_crisp` with `out_valid` high in the next cycle. Strength i sits in `in_str[8i+7:8i]` and pairs with singleton i.
- R5: The result is computed as follows. With S the sum of the strengths, each lane forms q = floor(|p|·256/S). The signed terms ±q·s are added, taking the sign of p. The total is shifted right arithmetically by 8 bits (a floor) and clamped to [-128, 127].
- R6: When all three strengths are zero, the result is 0.
- R7: A negative singleton, including -128, is divided by its magnitude and the sign is applied to its term.
- R8: A clock edge with `cfg_we` high and `cfg_sel` equal to 0, 1 or 2 loads `cfg_pos` (two's complement) into that singleton. Every triple accepted after that edge uses the new value.
- R9: A write with `cfg_sel` equal to 3 changes no singleton.
- R10: A triple accepted on the same edge as a singleton write uses the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Singleton write strobe |
| cfg_sel | input | 2 | Singleton index to write |
| cfg_pos | input | 8 | New singleton position, signed |
| in_valid | input | 1 | Strength triple is offered |
| in_ready | output | 1 | Block can take a triple this cycle |
| in_str | input | 24 | Three unsigned 8-bit rule strengths |
| out_valid | output | 1 | Crisp result is held |
| out_ready | input | 1 | Consumer takes the result |
| out_crisp | output | 8 | Crisp signed control value |

## Verification
The hardest case to reach is a singleton write that lands on the same clock edge as an accepted triple while the output is also being stalled and released. Only the exact ordering of those events separates old from new positions. The bench drives long stretches in which the strengths, `in_valid`, `out_ready` and the write strobe all toggle freely. A behavioural model updates its copy of the positions only after it has used them for that edge, and the two are compared on every clock. Directed cases add a -128 singleton with a full-scale strength and an all-zero triple, so the floor rounding at the negative extreme and the divide-by-zero guard are both exercised.

// File: rtl/defz_pkg.sv
package defz_pkg;

  // Default position of singleton idx, spread evenly over [-span, +span].
  function automatic int seat_pos(int idx, int nsets, int span);
    if (nsets < 2) return 0;
    return -span + (2 * span * idx) / (nsets - 1);
  endfunction

endpackage

// File: rtl/defz_nrdiv.sv
// Unsigned combinational non-restoring divider. Quotient digits come straight
// from the sign of each partial remainder, so no remainder fix-up is needed.
module defz_nrdiv #(
  parameter int N_W = 16,
  parameter int D_W = 10
) (
  input  logic [N_W-1:0] dvd,
  input  logic [D_W-1:0] dvs,
  output logic [N_W-1:0] quo
);
  localparam int RW = D_W + 3;

  logic signed [RW-1:0] dvs_x;
  assign dvs_x = signed'(RW'(dvs));

  always_comb begin
    logic signed [RW-1:0] part;
    logic signed [RW-1:0] shl;
    part = '0;
    quo  = '0;
    for (int k = N_W - 1; k >= 0; k--) begin
      shl  = {part[RW-2:0], dvd[k]};
      part = part[RW-1] ? (shl + dvs_x) : (shl - dvs_x);
      quo[k] = ~part[RW-1];
    end
  end
endmodule

// File: rtl/defz_lane.sv
// One singleton path: divide its magnitude by the strength sum, scale by its strength, restore the sign.
module defz_lane #(
  parameter int STR_W  = 8,
  parameter int POS_W  = 8,
  parameter int FRAC_W = 8,
  parameter int SUM_W  = 10,
  localparam int DVD_W  = POS_W + FRAC_W,
  localparam int PROD_W = DVD_W + STR_W + 1
) (
  input  logic [STR_W-1:0]         str,
  input  logic [POS_W-1:0]         pos,
  input  logic [SUM_W-1:0]         sum,
  output logic [POS_W-1:0]         mag_o,
  output logic [DVD_W-1:0]         quo_o,
  output logic signed [PROD_W-1:0] prod_o
);
  localparam int UP_W = DVD_W + STR_W;

  logic [POS_W-1:0] mag;
  logic [DVD_W-1:0] dvd;
  logic [UP_W-1:0]  uprod;
  logic signed [PROD_W-1:0] mag_prod;

  assign mag = pos[POS_W-1] ? (~pos + 1'b1) : pos;
  assign dvd = {mag, {FRAC_W{1'b0}}};

  defz_nrdiv #(.N_W(DVD_W), .D_W(SUM_W)) div_i (
    .dvd(dvd),
    .dvs(sum),
    .quo(quo_o)
  );

  assign uprod    = UP_W'(quo_o) * UP_W'(str);
  assign mag_prod = signed'({1'b0, uprod});
  assign prod_o   = pos[POS_W-1] ? -mag_prod : mag_prod;
  assign mag_o    = mag;
endmodule

// File: rtl/defz_singleton_bank.sv
module defz_singleton_bank
  import defz_pkg::*;
#(
  parameter int NSETS = 3,
  parameter int POS_W = 8,
  parameter int SPAN  = 96,
  localparam int SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  logic [POS_W-1:0]       cfg_pos,
  output logic [NSETS*POS_W-1:0] pos_flat
);
  for (genvar i = 0; i < NSETS; i++) begin : g_slot
    logic [POS_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= POS_W'(seat_pos(i, NSETS, SPAN));
      else if (cfg_we && cfg_sel == SEL_W'(i))
        slot_q <= cfg_pos;
    end

    assign pos_flat[i*POS_W +: POS_W] = slot_q;

    assert_slot_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SEL_W'(i)) |=> (pos_flat[i*POS_W +: POS_W] == $past(cfg_pos)));

    assert_bad_sel_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(cfg_sel) >= NSETS) |=> $stable(pos_flat[i*POS_W +: POS_W]));
  end
endmodule

// File: rtl/defz_centroid.sv
module defz_centroid #(
  parameter int NSETS  = 3,
  parameter int STR_W  = 8,
  parameter int POS_W  = 8,
  parameter int FRAC_W = 8,
  parameter int SPAN   = 96
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [((NSETS > 1) ? $clog2(NSETS) : 1)-1:0] cfg_sel,
  input  logic [POS_W-1:0]                  cfg_pos,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [NSETS*STR_W-1:0]            in_str,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [POS_W-1:0]                  out_crisp
);
  localparam int SEL_W  = (NSETS > 1) ? $clog2(NSETS) : 1;
  localparam int SUM_W  = STR_W + SEL_W;
  localparam int DVD_W  = POS_W + FRAC_W;
  localparam int PROD_W = DVD_W + STR_W + 1;
  localparam int ACC_W  = PROD_W + SEL_W;
  localparam logic signed [ACC_W-1:0] HI_LIM = ACC_W'((2 ** (POS_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LO_LIM = -ACC_W'(2 ** (POS_W - 1));

  logic [NSETS*POS_W-1:0]   pos_flat;
  logic [SUM_W-1:0]         sum;
  logic [POS_W-1:0]         mag_v  [NSETS];
  logic [DVD_W-1:0]         quo_v  [NSETS];
  logic signed [PROD_W-1:0] prod_v [NSETS];
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  scaled;
  logic [POS_W-1:0]         crisp_next;
  logic                     in_fire;

  defz_singleton_bank #(.NSETS(NSETS), .POS_W(POS_W), .SPAN(SPAN)) bank_i (
    .clk(clk),
    .rst_n(rst_n),
    .cfg_we(cfg_we),
    .cfg_sel(cfg_sel),
    .cfg_pos(cfg_pos),
    .pos_flat(pos_flat)
  );

  always_comb begin
    sum = '0;
    for (int i = 0; i < NSETS; i++)
      sum = sum + SUM_W'(in_str[i*STR_W +: STR_W]);
  end

  for (genvar i = 0; i < NSETS; i++) begin : g_lane
    defz_lane #(.STR_W(STR_W), .POS_W(POS_W), .FRAC_W(FRAC_W), .SUM_W(SUM_W)) lane_i (
      .str(in_str[i*STR_W +: STR_W]),
      .pos(pos_flat[i*POS_W +: POS_W]),
      .sum(sum),
      .mag_o(mag_v[i]),
      .quo_o(quo_v[i]),
      .prod_o(prod_v[i])
    );

    // The quotient must be the floor of magnitude*2^FRAC / sum.
    assert_quotient_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sum != '0) |->
        ((64'(quo_v[i]) * 64'(sum) <= (64'(mag_v[i]) << FRAC_W)) &&
         ((64'(mag_v[i]) << FRAC_W) < (64'(quo_v[i]) + 64'd1) * 64'(sum))));

    assert_negative_term_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_flat[i*POS_W + POS_W - 1] && quo_v[i] != '0 && in_str[i*STR_W +: STR_W] != '0)
        |-> (prod_v[i] < 0));
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NSETS; i++)
      acc = acc + ACC_W'(prod_v[i]);
    scaled = acc >>> FRAC_W;
    if (sum == '0)
      crisp_next = '0;
    else if (scaled > HI_LIM)
      crisp_next = HI_LIM[POS_W-1:0];
    else if (scaled < LO_LIM)
      crisp_next = LO_LIM[POS_W-1:0];
    else
      crisp_next = scaled[POS_W-1:0];
  end

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_crisp <= '0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      out_crisp <= crisp_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_crisp)));

  assert_accept_yields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_zero_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && sum == '0) |=> (out_crisp == '0));
endmodule

// File: tb/defz_centroid_tb_top.sv
module defz_centroid_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_pos = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_str = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_crisp;

  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  string cur_req = "R1";

  logic m_valid;
  int   m_data;
  int   m_pos [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  defz_centroid dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_pos(cfg_pos),
    .in_valid(in_valid), .in_ready(in_ready), .in_str(in_str),
    .out_valid(out_valid), .out_ready(out_ready), .out_crisp(out_crisp)
  );

  function automatic int ref_crisp(logic [23:0] st, int p0, int p1, int p2);
    int s [3];
    int p [3];
    int tot, sum, r;
    s[0] = int'(st[7:0]); s[1] = int'(st[15:8]); s[2] = int'(st[23:16]);
    p[0] = p0; p[1] = p1; p[2] = p2;
    sum = s[0] + s[1] + s[2];
    if (sum == 0) return 0;
    tot = 0;
    for (int k = 0; k < 3; k++) begin
      int mag, q;
      mag = (p[k] < 0) ? -p[k] : p[k];
      q = (mag * 256) / sum;
      tot += (p[k] < 0) ? -(q * s[k]) : (q * s[k]);
    end
    r = tot >>> 8;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  // Behavioural model of the output register and singleton store.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= 0;
      m_pos[0] <= -96; m_pos[1] <= 0; m_pos[2] <= 96;
    end else begin
      if (in_valid && (!m_valid || out_ready)) begin
        m_valid <= 1'b1;
        m_data  <= ref_crisp(in_str, m_pos[0], m_pos[1], m_pos[2]);
      end else if (out_ready) begin
        m_valid <= 1'b0;
      end
      if (cfg_we && cfg_sel != 2'd3)
        m_pos[cfg_sel] <= int'($signed(cfg_pos));
    end
  end

  always @(negedge clk) begin
    logic exp_rdy;
    exp_rdy = !m_valid || out_ready;
    compared++;
    if (out_valid !== m_valid || in_ready !== exp_rdy ||
        (m_valid && int'($signed(out_crisp)) != m_data)) begin
      mismatched++;
      $display("FAIL %s: valid=%0b ready=%0b crisp=%0d, expected valid=%0b ready=%0b crisp=%0d",
               cur_req, out_valid, in_ready, $signed(out_crisp), m_valid, exp_rdy, m_data);
    end
  end

  task automatic report_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual cycles %0d expected below 100000", cyc);
      report_end();
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic push(int a, int b, int c);
    logic hit;
    in_valid = 1'b1;
    in_str = {8'(c), 8'(b), 8'(a)};
    do begin
      hit = in_ready;
      step();
    end while (!hit);
    in_valid = 1'b0;
  endtask

  task automatic cfg_write(int sel, int val);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_pos = 8'(val);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rand_run(int n, bit rand_rdy, bit rand_cfg);
    for (int k = 0; k < n; k++) begin
      in_valid  = ($urandom % 3) != 0;
      in_str    = 24'($urandom);
      if (($urandom % 8) == 0) in_str[15:8] = 8'd0;
      out_ready = rand_rdy ? (($urandom % 2) == 1) : 1'b1;
      cfg_we    = rand_cfg && (($urandom % 6) == 0);
      cfg_sel   = 2'($urandom);
      cfg_pos   = 8'($urandom);
      step();
    end
    in_valid = 1'b0; cfg_we = 1'b0; out_ready = 1'b1;
    step();
  endtask

  initial begin
    // R1: reset state and default singletons
    repeat (3) step();
    rst_n = 1'b1;
    step();
    push(200, 40, 0);
    push(0, 0, 255);
    push(255, 0, 0);
    step();

    cur_req = "R4";
    push(10, 20, 30);
    push(1, 255, 1);
    push(128, 0, 128);
    push(3, 0, 0);
    step();

    cur_req = "R5";
    rand_run(300, 1'b0, 1'b0);

    cur_req = "R6";
    push(0, 0, 0);
    push(0, 7, 0);
    push(0, 0, 0);
    step();

    cur_req = "R7";
    cfg_write(0, -128);
    push(255, 0, 0);
    push(10, 3, 0);
    cfg_write(2, -77);
    push(0, 0, 5);
    push(1, 1, 250);
    step();

    cur_req = "R8";
    cfg_write(1, 50);
    push(0, 9, 0);
    cfg_write(0, 127);
    cfg_write(2, 127);
    push(255, 255, 255);
    step();

    cur_req = "R9";
    cfg_write(3, -5);
    push(1, 1, 1);
    push(200, 0, 3);
    step();

    cur_req = "R10";
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_pos = 8'd33;
    push(100, 0, 0);
    cfg_we = 1'b0;
    push(100, 0, 0);
    step();

    cur_req = "R3";
    out_ready = 1'b0;
    push(40, 40, 40);
    in_valid = 1'b1; in_str = {8'd9, 8'd9, 8'd9};
    repeat (4) step();
    out_ready = 1'b1;
    step();
    in_valid = 1'b0;
    step();

    cur_req = "R2";
    rand_run(600, 1'b1, 1'b1);
    repeat (3) step();
    report_end();
  end
endmodule